// File: doc/BRIEF.md
# Latching Input Transition Detector

This block watches a bank of general-purpose input pins for any departure from a stored reference image, called the snapshot. When a synchronized pin level differs from its snapshot bit, a sticky per-pin flag is set. An active-low interrupt is driven while any flag is set, except while a read is in progress. Because the comparison is against a snapshot taken only at bus accesses, a short pulse that returns to its old level before the next access still leaves its flag set.

A separate serial bus controller feeds the block single-cycle strobes:
- An address acknowledge, qualified by a group select and a read/write bit.
- A data acknowledge for each further byte of a read.
- A STOP marker.
- A marker that a serial write is about to change the pin levels.

An acknowledge to the I/O group reloads the snapshot from the pins and clears the flags. The flags from just before the clear are held on a separate output, so the controller can send them as the second byte of a read. A change seen during a read raises no interrupt until STOP. Pin movement caused by the bus's own writes is masked by a short quiet window.

Top module: `latch_tdet`

## Requirements
- R1: During reset and on the cycle it is released, `flags_o`, `rd_flags_o` are zero and `int_n_o` is 1. For `BLANK_CYC` cycles after release, the snapshot follows the synchronized pins and no flag can set. A pin change made one cycle after release therefore leaves all flags at zero.
- R2: Outside a read and outside a quiet window, a pin bit whose level differs from its snapshot bit sets flag bit i (same bit position) within `SYNC_STAGES`+1 clock edges. `int_n_o` is 0 whenever any flag is set outside a read.
- R3: Flags are sticky. A pin pulse of at least two cycles that returns to its old level leaves its flag set until the next clear.
- R4: An address acknowledge (`acc_ack_i`=1) with `grp_io_i`=1 (I/O group), for either read or write, does three things at that clock edge: it loads the snapshot from the synchronized pins, clears all flags, and releases `int_n_o` to 1. The flags from before the clear, including any mismatch present on that same cycle, appear on `rd_flags_o`.
- R5: An address acknowledge with `grp_io_i`=0 (push-pull group) leaves the flags, the snapshot and `int_n_o` unchanged.
- R6: `acc_rd_i`=1 on an I/O-group acknowledge starts a read, and `stop_i` ends it. While a read is in progress, `int_n_o` stays 1 and flags still accumulate. After STOP, `int_n_o` is 0 if any flag is set.
- R7: `byte_ack_i` during a read resamples the snapshot, clears the flags and captures the old flags in `rd_flags_o`, exactly as in R4. Outside a read, `byte_ack_i` has no effect.
- R8: `wr_commit_i` opens a window of `BLANK_CYC` cycles. In that window the snapshot follows the synchronized pins and no new flag sets; existing flags are kept. Pin changes after the window are detected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | PORTS | Asynchronous pin levels |
| acc_ack_i | input | 1 | Address acknowledge strobe |
| grp_io_i | input | 1 | 1 = access targets the I/O group, 0 = push-pull group |
| acc_rd_i | input | 1 | 1 = access is a read |
| byte_ack_i | input | 1 | Acknowledge of a further data byte in a read |
| stop_i | input | 1 | STOP condition strobe |
| wr_commit_i | input | 1 | A serial write is about to drive the pins |
| flags_o | output | PORTS | Live sticky change flags |
| rd_flags_o | output | PORTS | Flags captured at the most recent clear |
| int_n_o | output | 1 | Active-low interrupt |

## Verification
The checker holds every cycle on the following rules:
- Flags never drop without a clear (R3).
- Every I/O-group acknowledge or in-read byte acknowledge empties the flags on the next cycle (R4, R7).
- The interrupt is high throughout a read, and STOP ends the read (R6).
- The flags are frozen while the quiet window runs (R8).

Only the bench's scenarios can show the rest:
- The mapping from each toggled pin to its flag bit, swept over all 256 toggle masks (R2).
- Survival of a pulse that has already returned (R3).
- Recovery of the pre-clear flags on `rd_flags_o` (R4).
- The null effect of push-pull accesses and of stray byte acknowledges (R5, R7).
- The masking of pin moves early after reset and after a write commit (R1, R8).

// File: rtl/latch_tdet_pkg.sv
package latch_tdet_pkg;
  // control word passed from the access decoder to the detector core
  typedef struct packed {
    logic clear;   // resample snapshot, clear and capture flags
    logic quiet;   // snapshot follows pins, detection suspended
  } tdet_ctl_t;
endpackage

// File: rtl/latch_tdet_sync.sv
module latch_tdet_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/latch_tdet_ctl.sv
module latch_tdet_ctl
  import latch_tdet_pkg::*;
#(
  parameter int BLANK_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc_ack_i,
  input  logic      grp_io_i,
  input  logic      acc_rd_i,
  input  logic      byte_ack_i,
  input  logic      stop_i,
  input  logic      wr_commit_i,
  output tdet_ctl_t ctl_o,
  output logic      reading_o
);
  localparam int CNT_W = $clog2(BLANK_CYC + 1);

  logic             reading_q;
  logic [CNT_W-1:0] cnt_q;
  logic             io_ack;

  assign io_ack = acc_ack_i & grp_io_i;

  // read session: opened by an I/O-group read acknowledge, closed by STOP
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reading_q <= 1'b0;
    else if (io_ack) reading_q <= acc_rd_i;
    else if (stop_i) reading_q <= 1'b0;
  end

  // quiet window: armed by reset and by each write commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= CNT_W'(BLANK_CYC);
    else if (wr_commit_i)   cnt_q <= CNT_W'(BLANK_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign ctl_o.clear = io_ack | (byte_ack_i & reading_q);
  assign ctl_o.quiet = (cnt_q != '0);
  assign reading_o   = reading_q;
endmodule

// File: rtl/latch_tdet_core.sv
module latch_tdet_core
  import latch_tdet_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  tdet_ctl_t    ctl_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] held_o
);
  logic [W-1:0] snap_q, flags_q, held_q, hit;

  assign hit = ctl_i.quiet ? '0 : (sync_i ^ snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q  <= '0;
      flags_q <= '0;
      held_q  <= '0;
    end else if (ctl_i.clear) begin
      held_q  <= flags_q | hit;
      flags_q <= '0;
      snap_q  <= sync_i;
    end else if (ctl_i.quiet) begin
      snap_q  <= sync_i;
    end else begin
      flags_q <= flags_q | hit;
    end
  end

  assign flags_o = flags_q;
  assign held_o  = held_q;
endmodule

// File: rtl/latch_tdet.sv
module latch_tdet
  import latch_tdet_pkg::*;
#(
  parameter int PORTS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BLANK_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] pins_i,
  input  logic             acc_ack_i,
  input  logic             grp_io_i,
  input  logic             acc_rd_i,
  input  logic             byte_ack_i,
  input  logic             stop_i,
  input  logic             wr_commit_i,
  output logic [PORTS-1:0] flags_o,
  output logic [PORTS-1:0] rd_flags_o,
  output logic             int_n_o
);
  logic [PORTS-1:0] sync_w;
  tdet_ctl_t        ctl_w;
  logic             reading_w;
  logic             clear_w;
  logic             quiet_w;

  latch_tdet_sync #(.W(PORTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(sync_w)
  );

  latch_tdet_ctl #(.BLANK_CYC(BLANK_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .acc_ack_i(acc_ack_i), .grp_io_i(grp_io_i), .acc_rd_i(acc_rd_i),
    .byte_ack_i(byte_ack_i), .stop_i(stop_i), .wr_commit_i(wr_commit_i),
    .ctl_o(ctl_w), .reading_o(reading_w)
  );

  latch_tdet_core #(.W(PORTS)) u_core (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .ctl_i(ctl_w),
    .flags_o(flags_o), .held_o(rd_flags_o)
  );

  assign clear_w = ctl_w.clear;
  assign quiet_w = ctl_w.quiet;
  // interrupt held off for the whole read session
  assign int_n_o = ~((|flags_o) & ~reading_w);
endmodule

// File: rtl/latch_tdet_chk.sv
module latch_tdet_chk #(
  parameter int PORTS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_ack_i,
  input logic             grp_io_i,
  input logic             byte_ack_i,
  input logic             stop_i,
  input logic [PORTS-1:0] flags_o,
  input logic             int_n_o,
  input logic             reading_w,
  input logic             clear_w,
  input logic             quiet_w
);
  // R3
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_w |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  // R4
  io_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ack_i && grp_io_i) |=> (flags_o == '0 && int_n_o));

  // R7
  byte_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ack_i && reading_w && !acc_ack_i) |=> (flags_o == '0));

  // R6
  read_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reading_w |-> int_n_o);

  // R6
  stop_ends_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !acc_ack_i) |=> !reading_w);

  // R8
  quiet_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_w && !clear_w) |=> $stable(flags_o));
endmodule

bind latch_tdet latch_tdet_chk #(.PORTS(PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_ack_i(acc_ack_i), .grp_io_i(grp_io_i),
  .byte_ack_i(byte_ack_i), .stop_i(stop_i), .flags_o(flags_o),
  .int_n_o(int_n_o), .reading_w(reading_w), .clear_w(clear_w),
  .quiet_w(quiet_w)
);

// File: tb/latch_tdet_tb.sv
module latch_tdet_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic acc_ack = 0, grp_io = 0, acc_rd = 0, byte_ack = 0, stop = 0, wr_commit = 0;
  logic [N-1:0] flags, rd_flags;
  logic         int_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latch_tdet #(.PORTS(N), .SYNC_STAGES(2), .BLANK_CYC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .acc_ack_i(acc_ack),
    .grp_io_i(grp_io), .acc_rd_i(acc_rd), .byte_ack_i(byte_ack),
    .stop_i(stop), .wr_commit_i(wr_commit), .flags_o(flags),
    .rd_flags_o(rd_flags), .int_n_o(int_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ack(input logic g, input logic r);
    acc_ack = 1; grp_io = g; acc_rd = r; tick(1);
    acc_ack = 0; grp_io = 0; acc_rd = 0;
  endtask

  task automatic pulse_stop();
    stop = 1; tick(1); stop = 0;
  endtask

  task automatic pulse_byte();
    byte_ack = 1; tick(1); byte_ack = 0;
  endtask

  task automatic pulse_commit();
    wr_commit = 1; tick(1); wr_commit = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pins = 8'hA5;
    tick(3);
    rst_n = 1;
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 rd_flags", rd_flags, 0);
    chk("R1 int_n", int_n, 1);
    tick(1);
    pins = 8'h5A;   // inside the settle window
    tick(8);
    chk("R1 settle flags", flags, 0);
    chk("R1 settle int_n", int_n, 1);

    // sweep of every toggle mask
    for (int m = 0; m < 256; m++) begin
      ack(1, 0);
      chk("R4 write clear flags", flags, 0);
      chk("R4 write clear int_n", int_n, 1);
      pins ^= m[N-1:0]; tick(4);
      chk("R2 flag map", flags, m);
      chk("R2 int_n", int_n, (m == 0));
      ack(1, 1);
      chk("R4 rd_flags", rd_flags, m);
      chk("R4 read clear flags", flags, 0);
      chk("R6 int_n in read", int_n, 1);
      pulse_stop();
      chk("R6 int_n after quiet read", int_n, 1);
      pins ^= m[N-1:0]; tick(2); pins ^= m[N-1:0]; tick(4);
      chk("R3 sticky pulse", flags, m);
      chk("R3 int_n", int_n, (m == 0));
      ack(0, 0);
      chk("R5 push-pull ack flags", flags, m);
      chk("R5 push-pull ack int_n", int_n, (m == 0));
      pulse_byte();
      chk("R7 stray byte ack flags", flags, m);
    end

    // R6 change during read reported at STOP
    ack(1, 0);
    ack(1, 1);
    pins ^= 8'h01; tick(4);
    chk("R6 held off int_n", int_n, 1);
    chk("R6 flags accumulate", flags, 8'h01);
    pulse_stop();
    chk("R6 int_n at stop", int_n, 0);

    // R7 multibyte resample
    ack(1, 0);
    ack(1, 1);
    pins ^= 8'h02; tick(4);
    pulse_byte();
    chk("R7 resample rd_flags", rd_flags, 8'h02);
    chk("R7 resample flags", flags, 0);
    pins ^= 8'h04; tick(4);
    chk("R7 int_n in read", int_n, 1);
    pulse_stop();
    chk("R7 flags after stop", flags, 8'h04);
    chk("R7 int_n after stop", int_n, 0);

    // R8 write-caused pin moves are masked
    ack(1, 0);
    pulse_commit();
    pins ^= 8'h81; tick(6);
    chk("R8 masked flags", flags, 0);
    chk("R8 masked int_n", int_n, 1);
    pins ^= 8'h10; tick(4);
    chk("R8 after window flags", flags, 8'h10);
    chk("R8 after window int_n", int_n, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule